// File: doc/BRIEF.md
# Pi/4-Shift QPSK Burst Modulator Front End

This block turns a serial transmit bit stream into a sequence of pi/4-shift QPSK constellation points for a downstream pulse-shaping filter. Bits arrive at 384 kbps. Each pair of bits sampled inside the transmit window becomes one symbol. The first bit of the pair is the more significant bit of the dibit. Each dibit advances an eight-state carrier phase. The block outputs signed I and Q values for that phase, scaled by a burst amplitude level. The level rises over two symbols when the window opens and falls over two symbols after the window closes. An unsigned envelope value and a burst-active flag come out alongside.

The bit clock is taken from an input pin in one of two ways. The pin can carry a continuous 384 kHz clock, and then every rising edge samples a bit. The pin can instead carry a 3.84 MHz clock, and then the block divides it by ten and samples a bit on each rising edge of the divided clock. The clock output pin carries the pass-through clock or the divided clock. In pass-through mode it can instead carry the delayed burst window. A modulation-off control pins the carrier phase at zero. All outputs trail the input by a fixed pipeline counted in bit periods.

The block runs on a fast system clock. The transmit clock pin is oversampled, so every output change follows a sampled bit by a fixed number of system clocks.

Top module: `qpsk_burst_mod`

## Requirements
- R1: With `div_sel`=1, one bit is sampled on every tenth rising edge of `txc_in`. `txc_out` is then the divided clock, high for five input periods and low for five, and it goes high at the edge where the bit is sampled.
- R2: With `div_sel`=0, every rising edge of `txc_in` samples a bit. While `burst_win_en`=0, `txc_out` follows `txc_in` one system clock later.
- R3: With `div_sel`=0 and `burst_win_en`=1, `txc_out` equals `burst_act`. With `div_sel`=1, `burst_win_en` has no effect on `txc_out`.
- R4: A window opening is a sampled bit with `tx_win`=1 whose previous sampled bit had `tx_win`=0. At a window opening the phase is cleared to 0 and that bit becomes the first bit of a new dibit. The ramp level keeps its current value, even part-way through a ramp-down.
- R5: At each symbol the phase, counted in units of pi/4 modulo 8, advances as follows: dibit 00 adds 1, dibit 01 adds 3, dibit 11 adds 5 (that is, -3), and dibit 10 adds 7 (that is, -1). The first sampled bit of the pair is the dibit MSB.
- R6: Before scaling, I is taken from the phase as follows: 0 gives 127, 1 gives 89, 2 gives 0, 3 gives -89, 4 gives -127, 5 gives -89, 6 gives 0 and 7 gives 89. The value 89 is (127*181)/256. Q for phase p is the I value for phase p-2. Both are multiplied by level/2, with the result truncated toward zero.
- R7: Inside the window the ramp level is 1 after the first symbol and 2 after the second, and it stays at 2. `env` = (127*level)/2, which gives 0, 63 or 127.
- R8: After the window closes, the bits are taken as 0 and symbols continue. The level drops to 1 at the next symbol and to 0 at the one after.
- R9: While the level is 0, `sym_i`, `sym_q`, `env` and `burst_act` are 0. Bits sampled with `tx_win`=0 at level 0 change nothing.
- R10: With `mod_off`=1 the phase is 0 after every symbol, so Q is 0 and I is 127 scaled by the level.
- R11: The outputs present after bit sample k show the symbol state after bit sample k-12, which is six symbols back. Between bit samples the outputs do not change.
- R12: After reset, `sym_i`, `sym_q`, `env` and `burst_act` are 0. `txc_out` is 0 in pass-through mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples `txc_in` |
| rst_n | input | 1 | Asynchronous active-low reset |
| txc_in | input | 1 | Transmit clock pin, 384 kHz or 3.84 MHz |
| tx_data | input | 1 | Serial transmit bit |
| tx_win | input | 1 | Transmit window strobe |
| div_sel | input | 1 | 1: divide `txc_in` by ten; 0: use it as the bit clock |
| mod_off | input | 1 | Hold the carrier phase at 0 |
| burst_win_en | input | 1 | In pass-through mode, put the burst window on `txc_out` |
| txc_out | output | 1 | Bit clock or burst window output |
| sym_i | output | 8 | Signed in-phase value |
| sym_q | output | 8 | Signed quadrature value |
| env | output | 8 | Unsigned burst envelope |
| burst_act | output | 1 | Delayed burst-active flag, level not zero |

## Verification
The hardest case to reach from the ports is a window that reopens while a ramp-down is still running. The phase must restart at zero, but the level must climb from 1 and not from 0. The stimulus closes the window for exactly one symbol after a full-level burst and then opens it again, so the reopening lands while the level is 1. The divide-by-ten mode is also hard to reach, because a bit is sampled only on every tenth input edge. The bench therefore holds each bit for ten input periods and counts the high samples of the output clock in every bit period.

// File: rtl/qbm_pkg.sv
package qbm_pkg;

  localparam int IQ_W = 8;

  typedef struct packed {
    logic                   burst;
    logic signed [IQ_W-1:0] i;
    logic signed [IQ_W-1:0] q;
    logic        [IQ_W-1:0] env;
  } sym_rec_t;

  // phase increment in pi/4 units for one dibit (MSB = first bit)
  function automatic logic [2:0] dibit_step(input logic [1:0] d);
    case (d)
      2'b00:   return 3'd1;
      2'b01:   return 3'd3;
      2'b11:   return 3'd5;
      default: return 3'd7;
    endcase
  endfunction

  function automatic int diag_level(input int amp);
    return (amp * 181) / 256;
  endfunction

  // cosine of ph*pi/4 at amplitude amp
  function automatic int axis_cos(input logic [2:0] ph, input int amp);
    int mag;
    if (ph[0])      mag = diag_level(amp);
    else if (ph[1]) mag = 0;
    else            mag = amp;
    if (ph >= 3'd3 && ph <= 3'd5) return -mag;
    return mag;
  endfunction

  function automatic logic signed [IQ_W-1:0] scale_iq(input int v, input int lvl,
                                                      input int ramp);
    return IQ_W'((v * lvl) / ramp);
  endfunction

  function automatic logic [IQ_W-1:0] env_level(input int lvl, input int amp,
                                                input int ramp);
    return IQ_W'((amp * lvl) / ramp);
  endfunction

endpackage

// File: rtl/qbm_clkgen.sv
module qbm_clkgen #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txc_in,
  input  logic tx_data,
  input  logic tx_win,
  input  logic div_sel,
  output logic bit_tick,
  output logic bit_val,
  output logic win_val,
  output logic div_clk,
  output logic pass_clk
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic          txc_s1, txc_s2, data_s1, win_s1;
  logic          edge_rise;
  logic [CW-1:0] div_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txc_s1  <= 1'b0;
      txc_s2  <= 1'b0;
      data_s1 <= 1'b0;
      win_s1  <= 1'b0;
    end else begin
      txc_s1  <= txc_in;
      txc_s2  <= txc_s1;
      data_s1 <= tx_data;
      win_s1  <= tx_win;
    end
  end

  assign edge_rise = txc_s1 & ~txc_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         div_cnt <= '0;
    else if (edge_rise) div_cnt <= (div_cnt == CW'(DIV-1)) ? '0 : div_cnt + 1'b1;
  end

  assign bit_tick = div_sel ? (edge_rise && div_cnt == CW'(DIV-1)) : edge_rise;
  assign div_clk  = (div_cnt < CW'(DIV/2));
  assign pass_clk = txc_s1;
  assign bit_val  = data_s1;
  assign win_val  = win_s1;

endmodule

// File: rtl/qbm_symbolizer.sv
module qbm_symbolizer
  import qbm_pkg::*;
#(
  parameter int RAMP_SYMS = 2,
  parameter int AMP       = 127,
  parameter int LVL_W     = $clog2(RAMP_SYMS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             bit_val,
  input  logic             win_val,
  input  logic             mod_off,
  output sym_rec_t         cur,
  output logic             sym_stb,
  output logic             win_rise_evt,
  output logic [2:0]       phase,
  output logic [LVL_W-1:0] lvl
);
  logic       win_prev, have_first, first_bit, active;
  logic [1:0] dibit;

  assign win_rise_evt = bit_tick & win_val & ~win_prev;
  assign active       = win_val | (lvl != '0);
  assign sym_stb      = bit_tick & ~win_rise_evt & active & have_first;
  assign dibit        = {first_bit, bit_val & win_val};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_prev   <= 1'b0;
      have_first <= 1'b0;
      first_bit  <= 1'b0;
      phase      <= 3'd0;
      lvl        <= '0;
    end else if (bit_tick) begin
      win_prev <= win_val;
      if (win_rise_evt) begin
        phase      <= 3'd0;
        have_first <= 1'b1;
        first_bit  <= bit_val;
      end else if (active) begin
        if (!have_first) begin
          have_first <= 1'b1;
          first_bit  <= bit_val & win_val;
        end else begin
          have_first <= 1'b0;
          phase      <= mod_off ? 3'd0 : phase + dibit_step(dibit);
          if (win_val) lvl <= (lvl == LVL_W'(RAMP_SYMS)) ? lvl : lvl + 1'b1;
          else         lvl <= lvl - 1'b1;
        end
      end
    end
  end

  always_comb begin
    cur.burst = (lvl != '0);
    cur.i     = scale_iq(axis_cos(phase, AMP), int'(lvl), RAMP_SYMS);
    cur.q     = scale_iq(axis_cos(3'(phase - 3'd2), AMP), int'(lvl), RAMP_SYMS);
    cur.env   = env_level(int'(lvl), AMP, RAMP_SYMS);
  end

endmodule

// File: rtl/qbm_delay_line.sv
module qbm_delay_line
  import qbm_pkg::*;
#(
  parameter int LAT = 12
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     adv,
  input  sym_rec_t din,
  output sym_rec_t dout
);
  if (LAT == 0) begin : g_bypass
    assign dout = din;
  end else begin : g_chain
    sym_rec_t pipe [LAT];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int j = 0; j < LAT; j++) pipe[j] <= '0;
      end else if (adv) begin
        pipe[0] <= din;
        for (int j = 1; j < LAT; j++) pipe[j] <= pipe[j-1];
      end
    end
    assign dout = pipe[LAT-1];
  end

endmodule

// File: rtl/qpsk_burst_mod.sv
module qpsk_burst_mod
  import qbm_pkg::*;
#(
  parameter int DIV       = 10,
  parameter int RAMP_SYMS = 2,
  parameter int AMP       = 127,
  parameter int LAT_TICKS = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   txc_in,
  input  logic                   tx_data,
  input  logic                   tx_win,
  input  logic                   div_sel,
  input  logic                   mod_off,
  input  logic                   burst_win_en,
  output logic                   txc_out,
  output logic signed [IQ_W-1:0] sym_i,
  output logic signed [IQ_W-1:0] sym_q,
  output logic        [IQ_W-1:0] env,
  output logic                   burst_act
);
  localparam int LVL_W = $clog2(RAMP_SYMS + 1);

  logic             bit_tick, bit_val, win_val, div_clk, pass_clk;
  logic             sym_stb, win_rise_evt;
  logic [2:0]       phase;
  logic [LVL_W-1:0] lvl;
  sym_rec_t         cur_rec, out_rec;

  qbm_clkgen #(.DIV(DIV)) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .txc_in   (txc_in),
    .tx_data  (tx_data),
    .tx_win   (tx_win),
    .div_sel  (div_sel),
    .bit_tick (bit_tick),
    .bit_val  (bit_val),
    .win_val  (win_val),
    .div_clk  (div_clk),
    .pass_clk (pass_clk)
  );

  qbm_symbolizer #(.RAMP_SYMS(RAMP_SYMS), .AMP(AMP), .LVL_W(LVL_W)) u_sym (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_tick     (bit_tick),
    .bit_val      (bit_val),
    .win_val      (win_val),
    .mod_off      (mod_off),
    .cur          (cur_rec),
    .sym_stb      (sym_stb),
    .win_rise_evt (win_rise_evt),
    .phase        (phase),
    .lvl          (lvl)
  );

  qbm_delay_line #(.LAT(LAT_TICKS)) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (bit_tick),
    .din   (cur_rec),
    .dout  (out_rec)
  );

  always_comb begin
    if (div_sel)           txc_out = div_clk;
    else if (burst_win_en) txc_out = out_rec.burst;
    else                   txc_out = pass_clk;
  end

  assign sym_i     = out_rec.i;
  assign sym_q     = out_rec.q;
  assign env       = out_rec.env;
  assign burst_act = out_rec.burst;

endmodule

// File: rtl/qbm_checker.sv
module qbm_checker #(
  parameter int LVL_W     = 2,
  parameter int RAMP_SYMS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_tick,
  input logic              sym_stb,
  input logic              win_rise_evt,
  input logic              mod_off,
  input logic              div_sel,
  input logic              txc_out,
  input logic [2:0]        phase,
  input logic [LVL_W-1:0]  lvl,
  input logic signed [7:0] sym_i,
  input logic signed [7:0] sym_q,
  input logic [7:0]        env
);

  p_divclk_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (div_sel && bit_tick) |=> txc_out);

  p_phase_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    win_rise_evt |=> (phase == 3'd0));

  p_ramp_one_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sym_stb |=> (lvl == LVL_W'($past(lvl) + 1'b1)) ||
                (lvl == LVL_W'($past(lvl) - 1'b1)) ||
                (lvl == $past(lvl) && lvl == LVL_W'(RAMP_SYMS)));

  p_quiet_outputs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (env == 8'd0) |-> (sym_i == 8'sd0 && sym_q == 8'sd0));

  p_fixed_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_stb && mod_off) |=> (phase == 3'd0));

  p_hold_between_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> ($stable(sym_i) && $stable(sym_q) && $stable(env)));

endmodule

bind qpsk_burst_mod qbm_checker #(.LVL_W(LVL_W), .RAMP_SYMS(RAMP_SYMS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bit_tick     (bit_tick),
  .sym_stb      (sym_stb),
  .win_rise_evt (win_rise_evt),
  .mod_off      (mod_off),
  .div_sel      (div_sel),
  .txc_out      (txc_out),
  .phase        (phase),
  .lvl          (lvl),
  .sym_i        (sym_i),
  .sym_q        (sym_q),
  .env          (env)
);

// File: tb/tb_qpsk_burst_mod.sv
module tb_qpsk_burst_mod;
  localparam int CLK_P = 10;
  localparam int HALF  = 5;
  localparam int LAT   = 12;
  localparam int DIV   = 10;
  localparam int AMP   = 127;
  localparam int DIAG  = 89;
  localparam int RAMP  = 2;

  // {data[11:0], div_sel, mod_off, burst_win_en, expected phase after 6 symbols}
  localparam int NVEC = 6;
  localparam logic [17:0] VEC [NVEC] = '{
    {12'h000, 1'b0, 1'b0, 1'b0, 3'd6},
    {12'h555, 1'b1, 1'b0, 1'b0, 3'd2},
    {12'hFFF, 1'b0, 1'b0, 1'b1, 3'd6},
    {12'hAAA, 1'b1, 1'b0, 1'b1, 3'd2},
    {12'h1B1, 1'b0, 1'b0, 1'b0, 3'd4},
    {12'h555, 1'b0, 1'b1, 1'b0, 3'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0, txc_in = 1'b0, tx_data = 1'b0, tx_win = 1'b0;
  logic div_sel = 1'b0, mod_off = 1'b0, burst_win_en = 1'b0;
  logic txc_out, burst_act;
  logic signed [7:0] sym_i, sym_q;
  logic [7:0] env;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int m_phase, m_lvl, m_have, m_first, m_wprev, k;
  int h_i [256], h_q [256], h_env [256], h_b [256];
  int d_i [256], d_q [256], d_env [256];

  always #(CLK_P/2) clk = ~clk;

  qpsk_burst_mod dut (
    .clk(clk), .rst_n(rst_n), .txc_in(txc_in), .tx_data(tx_data), .tx_win(tx_win),
    .div_sel(div_sel), .mod_off(mod_off), .burst_win_en(burst_win_en),
    .txc_out(txc_out), .sym_i(sym_i), .sym_q(sym_q), .env(env), .burst_act(burst_act)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (tick %0d)", tag, act, exp, k);
    end
  endtask

  function automatic int ref_i(input int ph);
    case (ph & 7)
      0: return AMP;   1: return DIAG;  2: return 0;     3: return -DIAG;
      4: return -AMP;  5: return -DIAG; 6: return 0;     default: return DIAG;
    endcase
  endfunction

  function automatic int ref_q(input int ph);
    case (ph & 7)
      0: return 0;     1: return DIAG;  2: return AMP;   3: return DIAG;
      4: return 0;     5: return -DIAG; 6: return -AMP;  default: return -DIAG;
    endcase
  endfunction

  function automatic int ref_step(input int d);
    case (d)
      0: return 1;  1: return 3;  3: return 5;  default: return 7;
    endcase
  endfunction

  task automatic apply_reset(input logic sel, input logic moff, input logic ben);
    @(negedge clk);
    rst_n = 1'b0; txc_in = 1'b0; tx_data = 1'b0; tx_win = 1'b0;
    div_sel = sel; mod_off = moff; burst_win_en = ben;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    m_phase = 0; m_lvl = 0; m_have = 0; m_first = 0; m_wprev = 0; k = 0;
  endtask

  task automatic send_bit(input int b, input int w);
    int nper, high_cnt, ei, eq, ee, eb;
    logic hi_seen;
    tx_data = b[0]; tx_win = w[0];
    nper = div_sel ? DIV : 1;
    high_cnt = 0; hi_seen = 1'b0;
    for (int p = 0; p < nper; p++) begin
      @(negedge clk) txc_in = 1'b1;
      repeat (2) @(negedge clk);
      hi_seen = txc_out;
      repeat (HALF-2) @(negedge clk);
      txc_in = 1'b0;
      repeat (HALF) @(negedge clk);
      if (txc_out) high_cnt++;
    end
    // reference model of the sampled bit
    if (w != 0 && m_wprev == 0) begin
      m_phase = 0; m_have = 1; m_first = b;
    end else if (w != 0 || m_lvl != 0) begin
      if (m_have == 0) begin
        m_have = 1; m_first = (w != 0) ? b : 0;
      end else begin
        m_have = 0;
        m_phase = mod_off ? 0 : (m_phase + ref_step(m_first*2 + ((w != 0) ? b : 0))) % 8;
        if (w != 0) m_lvl = (m_lvl < RAMP) ? m_lvl + 1 : m_lvl;
        else        m_lvl = m_lvl - 1;
      end
    end
    m_wprev = w;
    h_b[k] = (m_lvl != 0) ? 1 : 0;
    h_i[k] = ref_i(m_phase) * m_lvl / RAMP;
    h_q[k] = ref_q(m_phase) * m_lvl / RAMP;
    h_env[k] = AMP * m_lvl / RAMP;
    if (k >= LAT) begin
      ei = h_i[k-LAT]; eq = h_q[k-LAT]; ee = h_env[k-LAT]; eb = h_b[k-LAT];
    end else begin
      ei = 0; eq = 0; ee = 0; eb = 0;
    end
    chk("R6 sym_i", int'(sym_i), ei);
    chk("R6 sym_q", int'(sym_q), eq);
    chk("R7 env", int'(env), ee);
    chk("R9 burst_act", int'(burst_act), eb);
    if (div_sel) chk("R1 divided clock high samples", high_cnt, 5);
    else if (!burst_win_en) begin
      chk("R2 txc_out high", int'(hi_seen), 1);
      chk("R2 txc_out low", int'(txc_out), 0);
    end else chk("R3 txc_out burst window", int'(txc_out), eb);
    d_i[k] = int'(sym_i); d_q[k] = int'(sym_q); d_env[k] = int'(env);
    k++;
  endtask

  task automatic run_entry(input int idx);
    logic [11:0] data;
    int k_start, k_last, ph;
    data = VEC[idx][17:6];
    ph = int'(VEC[idx][2:0]);
    apply_reset(VEC[idx][5], VEC[idx][4], VEC[idx][3]);
    for (int n = 0; n < 4; n++) send_bit(1, 0);   // R9: ignored outside window
    k_start = k;
    for (int n = 0; n < 12; n++) send_bit(int'(data[11-n]), 1);
    k_last = k - 1;
    for (int n = 0; n < 4; n++) send_bit(1, 0);
    for (int n = 0; n < LAT + 2; n++) send_bit(0, 0);
    if (VEC[idx][4]) begin
      chk("R10 fixed phase I", d_i[k_last+LAT], AMP);
      chk("R10 fixed phase Q", d_q[k_last+LAT], 0);
    end else begin
      chk("R5 final phase I", d_i[k_last+LAT], ref_i(ph));
      chk("R5 final phase Q", d_q[k_last+LAT], ref_q(ph));
    end
    chk("R11 still idle at latency", d_env[k_start+LAT], 0);
    chk("R7 first ramp symbol", d_env[k_start+1+LAT], 63);
    chk("R7 second ramp symbol", d_env[k_start+3+LAT], 127);
    chk("R8 first ramp-down symbol", d_env[k_last+2+LAT], 63);
    chk("R8 second ramp-down symbol", d_env[k_last+4+LAT], 0);
  endtask

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R12 reset state
    apply_reset(1'b0, 1'b0, 1'b0);
    chk("R12 sym_i after reset", int'(sym_i), 0);
    chk("R12 sym_q after reset", int'(sym_q), 0);
    chk("R12 env after reset", int'(env), 0);
    chk("R12 burst_act after reset", int'(burst_act), 0);
    chk("R12 txc_out after reset", int'(txc_out), 0);

    for (int v = 0; v < NVEC; v++) run_entry(v);

    // R4: window reopens during ramp-down
    apply_reset(1'b0, 1'b0, 1'b0);
    send_bit(0, 0); send_bit(0, 0);
    send_bit(0, 1); send_bit(1, 1); send_bit(1, 1); send_bit(1, 1);
    send_bit(0, 0); send_bit(0, 0);
    send_bit(1, 1); send_bit(0, 1);
    for (int n = 0; n < 4; n++) send_bit(0, 0);
    for (int n = 0; n < LAT + 2; n++) send_bit(0, 0);
    chk("R8 level one during gap", d_env[7+LAT], 63);
    chk("R4 restart phase I", d_i[9+LAT], DIAG);
    chk("R4 restart phase Q", d_q[9+LAT], -DIAG);
    chk("R4 level continues to full", d_env[9+LAT], 127);

    // R12 reset in mid-burst clears outputs
    apply_reset(1'b0, 1'b0, 1'b0);
    for (int n = 0; n < 20; n++) send_bit(n % 2, 1);
    chk("R7 mid-burst envelope", int'(env), 127);
    apply_reset(1'b0, 1'b0, 1'b0);
    chk("R12 env after mid-burst reset", int'(env), 0);
    chk("R12 sym_i after mid-burst reset", int'(sym_i), 0);
    chk("R12 burst_act after mid-burst reset", int'(burst_act), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule